// File: doc/BRIEF.md
# Programmable Interval Timer with Waveform Output

This block is one timer channel with a 16-bit up-counter, a power-of-two clock prescaler and one compare value. The compare value shapes a square or PWM wave on an output pin. Software sets it up through a small register port. Each access is one clock cycle, marked by a write strobe or a read strobe, and the read data is registered.

In interval mode the counter restarts from zero after it reaches the programmed interval value. This sets the period of the output wave. In match mode the output changes level when the count reaches the compare value, and it returns low at every wrap. This sets the duty cycle. Wrap and match events raise status flags only when their enable bits are set. Software clears a flag by writing a 1 to it, and the interrupt line is the OR of all enabled pending flags.

After reset the channel is halted and its output is low. Software programs the prescaler, the interval and the compare value. It then clears the halt bit, usually together with the self-clearing restart bit.

Register map (3-bit address, 16-bit data):
- 0 clock setup: bit 0 prescale enable, bits 4:1 prescale code N.
- 1 control: bit 0 halt, bit 1 wave off, bit 2 interval mode, bit 3 match mode, bit 4 restart (write only).
- 2 interval value.
- 3 compare value.
- 4 status, write 1 to clear: bit 0 wrap flag, bit 1 match flag.
- 5 flag enable: same bit layout as status.
- 6 and 7 read as 0.

Top module: `ivt_timer`

## Requirements
- R1: After reset every register reads 0 except control, which reads 0x0001 (halt set), and wave_o and irq_o are 0.
- R2: While the halt bit (control bit 0) is 1 the count and the prescaler hold, and no wrap or match event occurs.
- R3: With the prescale enable (clock setup bit 0) clear, the count advances on every clock. With it set, the count advances once every 2^(N+1) clocks, where N is clock setup bits 4:1.
- R4: In interval mode (control bit 2) the count steps from the interval value back to 0 and raises a wrap event. The period is therefore interval+1 count steps.
- R5: With interval mode clear, the count runs freely and wraps from 0xFFFF to 0, which also raises a wrap event.
- R6: In match mode (control bit 3) the internal wave toggles on the step that makes the count equal to the compare value. On every wrap the wave goes to 0, and the wrap takes precedence.
- R7: wave_o is the internal wave registered one cycle later, and forced to 0 while the wave off bit (control bit 1) is 1.
- R8: A wrap event sets status bit 0 and a match event sets status bit 1, but only when the same bit of the flag enable register is 1.
- R9: Writing status clears each bit written as 1. A flag set in the same cycle wins over the clear.
- R10: Writing control with bit 4 set restarts the count, the prescaler and the wave at 0 and suppresses events in that cycle. Bit 4 reads back as 0.
- R11: irq_o is 1 in the cycle after any status bit and its enable bit are both 1.
- R12: Read data is updated on the clock edge that samples rd_en, from register values before that edge, and holds while rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench applies the following patterns:
- A short interval with a mid compare value and no prescaling. This separates the off-by-one period (interval+1) from a period of interval, and a toggle on the step into the compare value from a toggle one step later.
- A prescaled run with code 2. This shows whether the divisor is 2^(N+1) rather than 2^N.
- A free-running run longer than 65536 cycles. This separates the wrap at 0xFFFF from the interval wrap.
- Runs with flags disabled, with the wave off, and with restart. These exercise the gating paths.

A behavioural model is compared against the design on every cycle, alongside direct read-back checks with fixed expected values.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CLKSET = 3'd0,
    A_CTRL   = 3'd1,
    A_INTV   = 3'd2,
    A_MATCH  = 3'd3,
    A_STS    = 3'd4,
    A_IEN    = 3'd5
  } reg_addr_e;

  // control bit positions
  localparam int C_HALT    = 0;
  localparam int C_WOFF    = 1;
  localparam int C_IMODE   = 2;
  localparam int C_MMODE   = 3;
  localparam int C_RESTART = 4;

  // status / enable bit positions
  localparam int F_WRAP  = 0;
  localparam int F_MATCH = 1;

  typedef struct packed {
    logic mmode;
    logic imode;
    logic woff;
    logic halt;
  } ctrl_t;
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              tick
);
  localparam int PRE_W = 1 << CODE_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   lim_w;
  logic             hit;

  always_comb begin
    lim_w = ((PRE_W+1)'(1) << (int'(code) + 1)) - (PRE_W+1)'(1);
    hit   = (pre_q == lim_w[PRE_W-1:0]);
    tick  = run && (!en || hit);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
    end else if (run && en) begin
      pre_q <= hit ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         restart,
  input  logic         imode,
  input  logic         mmode,
  input  logic [W-1:0] intv,
  input  logic [W-1:0] match,
  output logic [W-1:0] cnt,
  output logic         wrap_evt,
  output logic         match_evt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;
  logic         at_top;
  logic         step;

  always_comb begin
    step      = tick && !restart;
    at_top    = imode ? (cnt_q == intv) : (cnt_q == {W{1'b1}});
    nxt       = at_top ? '0 : cnt_q + 1'b1;
    wrap_evt  = step && at_top;
    match_evt = step && mmode && (nxt == match);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= nxt;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ivt_wave.sv
module ivt_wave (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic wrap_evt,
  input  logic match_evt,
  input  logic woff,
  output logic wave_q,
  output logic wave_o
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wave_q <= 1'b0;
    end else if (wrap_evt) begin
      wave_q <= 1'b0;
    end else if (match_evt) begin
      wave_q <= ~wave_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave_o <= 1'b0;
    else     wave_o <= wave_q && !woff;
  end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int W      = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [NFLAG-1:0]  evt,
  output logic [W-1:0]      rdata,
  output logic              ps_en,
  output logic [CODE_W-1:0] ps_code,
  output ctrl_t             ctrl,
  output logic              restart,
  output logic [W-1:0]      intv,
  output logic [W-1:0]      match,
  output logic [NFLAG-1:0]  sts,
  output logic [NFLAG-1:0]  ien,
  output logic              irq_o
);
  logic wr_clk, wr_ctrl, wr_intv, wr_match, wr_sts, wr_ien;
  logic [W-1:0] rd_mux;

  always_comb begin
    wr_clk   = wr_en && (addr == A_CLKSET);
    wr_ctrl  = wr_en && (addr == A_CTRL);
    wr_intv  = wr_en && (addr == A_INTV);
    wr_match = wr_en && (addr == A_MATCH);
    wr_sts   = wr_en && (addr == A_STS);
    wr_ien   = wr_en && (addr == A_IEN);
    restart  = wr_ctrl && wdata[C_RESTART];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_en   <= 1'b0;
      ps_code <= '0;
      ctrl    <= '{mmode: 1'b0, imode: 1'b0, woff: 1'b0, halt: 1'b1};
      intv    <= '0;
      match   <= '0;
      ien     <= '0;
    end else begin
      if (wr_clk) begin
        ps_en   <= wdata[0];
        ps_code <= wdata[CODE_W:1];
      end
      if (wr_ctrl) begin
        ctrl.halt  <= wdata[C_HALT];
        ctrl.woff  <= wdata[C_WOFF];
        ctrl.imode <= wdata[C_IMODE];
        ctrl.mmode <= wdata[C_MMODE];
      end
      if (wr_intv)  intv  <= wdata;
      if (wr_match) match <= wdata;
      if (wr_ien)   ien   <= wdata[NFLAG-1:0];
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                    sts[g] <= 1'b0;
      else if (evt[g] && ien[g])  sts[g] <= 1'b1;
      else if (wr_sts && wdata[g]) sts[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(sts & ien);
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CLKSET: rd_mux[CODE_W:0] = {ps_code, ps_en};
      A_CTRL: begin
        rd_mux[C_HALT]  = ctrl.halt;
        rd_mux[C_WOFF]  = ctrl.woff;
        rd_mux[C_IMODE] = ctrl.imode;
        rd_mux[C_MMODE] = ctrl.mmode;
      end
      A_INTV:  rd_mux = intv;
      A_MATCH: rd_mux = match;
      A_STS:   rd_mux[NFLAG-1:0] = sts;
      A_IEN:   rd_mux[NFLAG-1:0] = ien;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int W      = 16,
  parameter int CODE_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         wave_o,
  output logic         irq_o
);
  logic              ps_en;
  logic [CODE_W-1:0] ps_code;
  ctrl_t             ctrl;
  logic              restart;
  logic [W-1:0]      intv;
  logic [W-1:0]      match;
  logic [NFLAG-1:0]  sts;
  logic [NFLAG-1:0]  ien;
  logic [NFLAG-1:0]  evt;
  logic              tick;
  logic [W-1:0]      cnt;
  logic              wrap_evt;
  logic              match_evt;
  logic              wave_q;

  ivt_regs #(.W(W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .evt(evt), .rdata(rdata), .ps_en(ps_en),
    .ps_code(ps_code), .ctrl(ctrl), .restart(restart), .intv(intv),
    .match(match), .sts(sts), .ien(ien), .irq_o(irq_o)
  );

  ivt_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .run(!ctrl.halt), .en(ps_en), .code(ps_code),
    .restart(restart), .tick(tick)
  );

  ivt_count #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .imode(ctrl.imode), .mmode(ctrl.mmode), .intv(intv), .match(match),
    .cnt(cnt), .wrap_evt(wrap_evt), .match_evt(match_evt)
  );

  always_comb begin
    evt          = '0;
    evt[F_WRAP]  = wrap_evt;
    evt[F_MATCH] = match_evt;
  end

  ivt_wave u_wave (
    .clk(clk), .rst(rst), .restart(restart), .wrap_evt(wrap_evt),
    .match_evt(match_evt), .woff(ctrl.woff), .wave_q(wave_q),
    .wave_o(wave_o)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         halt,
  input logic         woff,
  input logic         restart,
  input logic [W-1:0] cnt,
  input logic         wrap_evt,
  input logic [1:0]   sts,
  input logic [1:0]   ien,
  input logic         wave_q,
  input logic         wave_o,
  input logic         irq_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wave_o && !irq_o));

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (halt && !restart) |=> $stable(cnt));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (cnt == '0));

  assert_woff_low_R7: assert property (@(posedge clk) disable iff (rst)
    woff |=> !wave_o);

  assert_flag_gated_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[0]) |-> $past(ien[0]));

  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !wave_q));

  assert_irq_high_R11: assert property (@(posedge clk) disable iff (rst)
    (|(sts & ien)) |=> irq_o);

  assert_irq_low_R11: assert property (@(posedge clk) disable iff (rst)
    !(|(sts & ien)) |=> !irq_o);
endmodule

bind ivt_timer ivt_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .halt(ctrl.halt), .woff(ctrl.woff),
  .restart(restart), .cnt(cnt), .wrap_evt(wrap_evt), .sts(sts), .ien(ien),
  .wave_q(wave_q), .wave_o(wave_o), .irq_o(irq_o)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wave_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  int cycles = 0;

  // reference model state
  int m_ps_en, m_code, m_halt, m_woff, m_im, m_mm, m_intv, m_match;
  int m_sts, m_ien, m_pre, m_cnt, m_wave;
  int m_rd, m_wo, m_irq;

  always #10 clk = ~clk;

  ivt_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wave_o(wave_o), .irq_o(irq_o)
  );

  function automatic int model_read(int a);
    case (a)
      0: return m_ps_en | (m_code << 1);
      1: return m_halt | (m_woff << 1) | (m_im << 2) | (m_mm << 3);
      2: return m_intv;
      3: return m_match;
      4: return m_sts;
      5: return m_ien;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ps_en = 0; m_code = 0; m_halt = 1; m_woff = 0; m_im = 0; m_mm = 0;
      m_intv = 0; m_match = 0; m_sts = 0; m_ien = 0; m_pre = 0; m_cnt = 0;
      m_wave = 0; m_rd = 0; m_wo = 0; m_irq = 0;
    end else begin
      int restart_w, tick, wrap, mev, nxt, lim, clr, ev;
      m_irq = ((m_sts & m_ien) != 0) ? 1 : 0;
      m_wo  = (m_wave == 1 && m_woff == 0) ? 1 : 0;
      if (rd_en) m_rd = model_read(int'(addr));
      restart_w = (wr_en && addr == 3'd1 && wdata[4]) ? 1 : 0;
      tick = 0;
      if (m_halt == 0) begin
        if (m_ps_en == 0) tick = 1;
        else begin
          lim = (1 << (m_code + 1)) - 1;
          tick = (m_pre == lim) ? 1 : 0;
        end
      end
      wrap = 0; mev = 0; nxt = m_cnt;
      if (tick && !restart_w) begin
        if (m_im) wrap = (m_cnt == m_intv) ? 1 : 0;
        else      wrap = (m_cnt == 65535) ? 1 : 0;
        nxt = wrap ? 0 : m_cnt + 1;
        mev = (m_mm && nxt == m_match) ? 1 : 0;
      end
      if (restart_w) begin
        m_pre = 0; m_cnt = 0; m_wave = 0;
      end else begin
        if (m_halt == 0 && m_ps_en == 1)
          m_pre = (m_pre == (1 << (m_code + 1)) - 1) ? 0 : m_pre + 1;
        m_cnt = nxt;
        if (wrap) m_wave = 0;
        else if (mev) m_wave = 1 - m_wave;
      end
      clr = (wr_en && addr == 3'd4) ? int'(wdata[1:0]) : 0;
      ev  = (wrap | (mev << 1)) & m_ien;
      m_sts = (m_sts & ~clr & 3) | ev;
      if (wr_en) begin
        case (addr)
          3'd0: begin m_ps_en = wdata[0]; m_code = int'(wdata[4:1]); end
          3'd1: begin m_halt = wdata[0]; m_woff = wdata[1];
                      m_im = wdata[2]; m_mm = wdata[3]; end
          3'd2: m_intv = int'(wdata);
          3'd3: m_match = int'(wdata);
          3'd5: m_ien = int'(wdata[1:0]);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      n_cmp++;
      if (int'(rdata) != m_rd) begin
        n_bad++;
        $display("FAIL %s rdata actual %0h expected %0h", cur_req, rdata, m_rd);
      end
      n_cmp++;
      if (int'(wave_o) != m_wo) begin
        n_bad++;
        $display("FAIL %s wave_o actual %0d expected %0d", cur_req, wave_o, m_wo);
      end
      n_cmp++;
      if (int'(irq_o) != m_irq) begin
        n_bad++;
        $display("FAIL %s irq_o actual %0d expected %0d", cur_req, irq_o, m_irq);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [15:0] exp,
                           input string req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read addr %0d actual %0h expected %0h", req, a, rdata, exp);
    end
  endtask

  task automatic pin_expect(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pin actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values, R12 registered read
    cur_req = "R1";
    pin_expect(wave_o, 1'b0, "R1");
    pin_expect(irq_o, 1'b0, "R1");
    rd_expect(3'd0, 16'h0000, "R1");
    rd_expect(3'd1, 16'h0001, "R1");
    rd_expect(3'd2, 16'h0000, "R1");
    rd_expect(3'd4, 16'h0000, "R12");
    // R2: halted, nothing moves
    cur_req = "R2";
    wr(3'd2, 16'd9); wr(3'd3, 16'd4); wr(3'd5, 16'h0003);
    repeat (30) @(negedge clk);
    rd_expect(3'd4, 16'h0000, "R2");
    // R4 R6: interval 9, match 4, no prescale
    cur_req = "R4_R6";
    wr(3'd1, 16'h001C);
    repeat (60) @(negedge clk);
    // R9: halt, clear flags, confirm cleared
    cur_req = "R9";
    wr(3'd1, 16'h000D);
    wr(3'd4, 16'h0003);
    rd_expect(3'd4, 16'h0000, "R9");
    @(negedge clk);
    pin_expect(irq_o, 1'b0, "R11");
    // R3: prescale code 2 (divide by 8)
    cur_req = "R3";
    wr(3'd0, 16'h0005);
    wr(3'd1, 16'h001C);
    repeat (300) @(negedge clk);
    wr(3'd0, 16'h001F);
    wr(3'd2, 16'd2); wr(3'd3, 16'd1);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h001C);
    repeat (80) @(negedge clk);
    wr(3'd0, 16'h0000);
    // R7: wave off
    cur_req = "R7";
    wr(3'd2, 16'd9); wr(3'd3, 16'd4);
    wr(3'd1, 16'h001E);
    repeat (40) @(negedge clk);
    pin_expect(wave_o, 1'b0, "R7");
    // R8: flags disabled
    cur_req = "R8";
    wr(3'd1, 16'h000D);
    wr(3'd4, 16'h0003);
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'h001C);
    repeat (50) @(negedge clk);
    rd_expect(3'd4, 16'h0000, "R8");
    pin_expect(irq_o, 1'b0, "R8");
    // R10: restart self-clears, mid-run restart
    cur_req = "R10";
    wr(3'd5, 16'h0001);
    repeat (7) @(negedge clk);
    wr(3'd1, 16'h001C);
    repeat (20) @(negedge clk);
    wr(3'd1, 16'h0019);
    rd_expect(3'd1, 16'h0009, "R10");
    // R5: free-running wrap at 0xFFFF
    cur_req = "R5";
    wr(3'd4, 16'h0003);
    wr(3'd5, 16'h0003);
    wr(3'd3, 16'd100);
    wr(3'd1, 16'h0018);
    repeat (65545) @(negedge clk);
    rd_expect(3'd4, 16'h0003, "R5");
    pin_expect(irq_o, 1'b1, "R11");
    // R9: set beats clear while running
    cur_req = "R9";
    wr(3'd4, 16'h0003);
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (190000) @(negedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired at %0d cycles", cycles);
    finish_run();
  end
endmodule